// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an external I2C controller read and write a 128-byte register file. A fast system clock oversamples SCL and SDA, and the block watches the two lines for START, repeated START and STOP. It answers a 7-bit bus address built from the fixed pattern `101110` and an address-select strap input. Its SDA output is open-drain, so it only ever pulls the line low. The port `sda_oe` shows when that pull-down is active.

In a write transfer, the first byte after the address is the sub-address. Its low seven bits set the register pointer. Every later byte is stored at the pointer and acknowledged. To read, the controller first writes the sub-address, then sends a repeated START with the read direction bit, and clocks bytes out. Bit 4 of register 0x11 controls pointer auto-increment. That register resets to 0x10, so auto-increment is on after reset.

Top module: `i2c_reg_target`

## Requirements
- R1: After a START, a first byte equal to {101110, addr_strap, dir} is acknowledged. The block drives `sda_oe` high for the whole ninth SCL clock. The write bytes are B8h/BAh and the read bytes are B9h/BBh, for strap 0/1.
- R2: Any other address byte gets no acknowledge. After it, `sda_oe` stays low and no register changes until the next START or STOP.
- R3: In a write transfer, the byte after the address is acknowledged and loads its bits 6:0 into the register pointer. Bit 7 is ignored.
- R4: Each later byte of a write transfer is acknowledged and stored in the register the pointer selects.
- R5: Registers reset to 0x00, except register 0x11, which resets to 0x10. While bit 4 of register 0x11 is 1, the pointer advances by one after each data byte written or read.
- R6: While that bit is 0, the pointer stays put. The bit's value before a byte is written decides whether the pointer steps after that byte, so a write that clears the bit still steps once.
- R7: Auto-increment wraps the pointer from 0x7F to 0x00.
- R8: A read entered by a repeated START returns the register contents MSB first, starting at the pointer. `sda_oe` is low during each acknowledge clock.
- R9: If the controller NACKs a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R10: A STOP returns the block to idle with SDA released. A START in any state, even in the middle of a byte, restarts address reception.
- R11: `sda_oe` changes only in the cycle after a detected SCL falling edge, START or STOP.
- R12: During and after reset, `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Sets the lowest bit of the bus address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A data byte written to register 0x11 can clear the auto-increment bit in the same cycle that the pointer step for that byte is decided. The bench provokes this with a four-byte burst starting at 0x10 whose second byte is 0x00. It then checks that register 0x12 received only the last byte, that 0x13 kept its reset value, and that later reads of 0x12 return the same value twice.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int PTR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_WDATA, ST_RDATA, ST_WAIT
  } i2ct_state_e;

  // pointer step: plus one with natural wrap, or hold
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                input logic inc);
    return inc ? p + 1'b1 : p;
  endfunction

  // address byte compare: bits 7:1 against {base, strap}
  function automatic logic addr_hit(input logic [7:0] b,
                                    input logic [5:0] base,
                                    input logic strap);
    return b[7:1] == {base, strap};
  endfunction
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pins_in,   // [0] = SCL, [1] = SDA
  output logic       sda_q,
  output logic       scl_rise,
  output logic       scl_fall,
  output logic       bus_start,
  output logic       bus_stop
);
  logic [1:0] sync_o;
  logic [1:0] prev_q;

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pins_in[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sync_o;
  end

  assign sda_q     = sync_o[1];
  assign scl_rise  =  sync_o[0] & ~prev_q[0];
  assign scl_fall  = ~sync_o[0] &  prev_q[0];
  assign bus_start =  sync_o[0] &  prev_q[0] &  prev_q[1] & ~sync_o[1];
  assign bus_stop  =  sync_o[0] &  prev_q[0] & ~prev_q[1] &  sync_o[1];
endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile
  import i2ct_pkg::*;
#(
  parameter logic [PTR_W-1:0] CTRL_ADDR = 7'h11,
  parameter int               INC_BIT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata,
  output logic             inc_en
);
  localparam int         DEPTH    = 1 << PTR_W;
  localparam logic [7:0] CTRL_RST = 8'(1 << INC_BIT);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i == int'(CTRL_ADDR)) ? CTRL_RST : 8'h00;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata  = mem_q[raddr];
  assign inc_en = mem_q[CTRL_ADDR][INC_BIT];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2ct_pkg::*;
#(
  parameter logic [5:0]       ADDR_BASE = 6'b101110,
  parameter logic [PTR_W-1:0] CTRL_ADDR = 7'h11,
  parameter int               INC_BIT   = 4,
  parameter int               SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic addr_strap,
  output logic sda_oe
);
  localparam int         CNT_W    = 4;
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(8);

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  i2ct_state_e state;
  logic [CNT_W-1:0] bitcnt;
  logic ack_ph, nack_q;
  logic [7:0] sh_q, tx_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] rd_addr;
  logic [7:0] rd_data;
  logic inc_en;

  // named events for checks and write port
  logic byte_done, slot_end, wr_fire, hit;

  i2ct_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_in({sda_in, scl_in}),
    .sda_q(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign byte_done = scl_fall & ~ack_ph & (bitcnt == BYTE_END) & ~bus_start & ~bus_stop;
  assign slot_end  = scl_fall & ack_ph & ~bus_start & ~bus_stop;
  assign wr_fire   = byte_done & (state == ST_WDATA);
  assign hit       = addr_hit(sh_q, ADDR_BASE, addr_strap);
  assign rd_addr   = (state == ST_RDATA) ? ptr_next(ptr_q, inc_en) : ptr_q;

  i2ct_regfile #(.CTRL_ADDR(CTRL_ADDR), .INC_BIT(INC_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(ptr_q), .wdata(sh_q),
    .raddr(rd_addr), .rdata(rd_data), .inc_en(inc_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      nack_q <= 1'b0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      sda_oe <= 1'b0;
    end else if (bus_start) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (bus_stop) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (state == ST_IDLE || state == ST_WAIT) begin
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (!ack_ph) begin
        sh_q   <= {sh_q[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end else begin
        nack_q <= sda_s;
      end
    end else if (byte_done) begin
      ack_ph <= 1'b1;
      unique case (state)
        ST_ADDR:  if (hit) sda_oe <= 1'b1; else state <= ST_WAIT;
        ST_SUB:   begin sda_oe <= 1'b1; ptr_q <= sh_q[PTR_W-1:0]; end
        ST_WDATA: begin sda_oe <= 1'b1; ptr_q <= ptr_next(ptr_q, inc_en); end
        default:  sda_oe <= 1'b0;
      endcase
    end else if (slot_end) begin
      ack_ph <= 1'b0;
      bitcnt <= '0;
      unique case (state)
        ST_ADDR: begin
          if (sh_q[0]) begin
            state  <= ST_RDATA;
            tx_q   <= rd_data;
            sda_oe <= ~rd_data[7];
          end else begin
            state  <= ST_SUB;
            sda_oe <= 1'b0;
          end
        end
        ST_SUB:  begin state <= ST_WDATA; sda_oe <= 1'b0; end
        ST_RDATA: begin
          ptr_q <= ptr_next(ptr_q, inc_en);
          if (nack_q) begin
            state  <= ST_WAIT;
            sda_oe <= 1'b0;
          end else begin
            tx_q   <= rd_data;
            sda_oe <= ~rd_data[7];
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end else if (scl_fall && state == ST_RDATA && bitcnt != '0) begin
      sda_oe <= ~tx_q[3'd7 - bitcnt[2:0]];
    end
  end

  // R11: output moves only after a falling SCL edge or a bus condition
  p_oe_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));

  // R2, R9: silent state never drives the line
  p_quiet_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  // R10: STOP lands in idle with SDA released
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state == ST_IDLE && !sda_oe));

  // R10: START restarts address reception from any state
  p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (state == ST_ADDR && bitcnt == '0));

  // R1: an acknowledge is held until the ninth clock falls
  p_ack_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ph && sda_oe && state != ST_RDATA && !scl_fall && !bus_start && !bus_stop)
      |=> sda_oe);

  // R7: auto-increment wraps at the top of the file
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && inc_en && ptr_q == '1) |=> (ptr_q == '0));
endmodule

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  logic sda_line;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [4];
  logic ack_all;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe)
  );

  // each entry: {sub-address, data}; readback from sub[6:0]
  localparam logic [15:0] VEC [6] = '{
    {8'h03, 8'hA5}, {8'h85, 8'h3C}, {8'h20, 8'hFF},
    {8'h7E, 8'h01}, {8'h40, 8'h80}, {8'h9A, 8'h5A}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(H/2);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(H/2); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0; wt(H/2);
    end
    sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(H/2);
    ack = ~sda_line;
    wt(H/2); scl = 1'b0; wt(H/2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); scl = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2); scl = 1'b0;
    end
    wt(1); sda_m = ~mack; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0; wt(H/2);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] adr(input logic rd);
    return {6'b101110, strap, rd};
  endfunction

  task automatic write_burst(input logic [7:0] sub, input logic [7:0] d0, d1, d2, d3,
                             input int n);
    logic a;
    ack_all = 1'b1;
    start_c();
    send_byte(adr(1'b0), a); ack_all &= a;
    send_byte(sub, a);       ack_all &= a;
    if (n > 0) begin send_byte(d0, a); ack_all &= a; end
    if (n > 1) begin send_byte(d1, a); ack_all &= a; end
    if (n > 2) begin send_byte(d2, a); ack_all &= a; end
    if (n > 3) begin send_byte(d3, a); ack_all &= a; end
    stop_c();
  endtask

  task automatic read_burst(input logic [7:0] sub, input int n);
    logic a;
    ack_all = 1'b1;
    start_c();
    send_byte(adr(1'b0), a); ack_all &= a;
    send_byte(sub, a);       ack_all &= a;
    start_c();
    send_byte(adr(1'b1), a); ack_all &= a;
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    wt(5);
    chk("R12 oe in reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    wt(10);
    chk("R12 oe after reset", {7'd0, sda_oe}, 8'h00);

    // R5 reset values
    read_burst(8'h11, 1); chk("R5 ctrl reset", rbuf[0], 8'h10);
    chk("R1 acks on B8/B9", {7'd0, ack_all}, 8'h01);
    read_burst(8'h00, 1); chk("R5 reg0 reset", rbuf[0], 8'h00);

    // table walk: R3 sub-address, R4 write, R8 read
    for (int v = 0; v < 6; v++) begin
      write_burst(VEC[v][15:8], VEC[v][7:0], 8'h00, 8'h00, 8'h00, 1);
      chk("R4 write acked", {7'd0, ack_all}, 8'h01);
      read_burst({1'b0, VEC[v][14:8]}, 1);
      chk("R3/R8 readback", rbuf[0], VEC[v][7:0]);
    end

    // R5 auto-increment burst
    write_burst(8'h30, 8'h11, 8'h22, 8'h33, 8'h44, 4);
    read_burst(8'h30, 4);
    chk("R5 burst b0", rbuf[0], 8'h11);
    chk("R5 burst b1", rbuf[1], 8'h22);
    chk("R5 burst b2", rbuf[2], 8'h33);
    chk("R5 burst b3", rbuf[3], 8'h44);

    // R7 wrap
    write_burst(8'h7F, 8'hC1, 8'hC2, 8'h00, 8'h00, 2);
    read_burst(8'h00, 1); chk("R7 wrap write", rbuf[0], 8'hC2);
    read_burst(8'h7F, 2);
    chk("R7 wrap read b0", rbuf[0], 8'hC1);
    chk("R7 wrap read b1", rbuf[1], 8'hC2);

    // R2 address mismatch: no ack, no writes
    start_c();
    send_byte(8'hBA, a); chk("R2 no ack", {7'd0, a}, 8'h00);
    send_byte(8'h00, a); chk("R2 silent", {7'd0, a}, 8'h00);
    send_byte(8'h55, a);
    stop_c();
    read_burst(8'h00, 1); chk("R2 reg0 kept", rbuf[0], 8'hC2);

    // R1 strap = 1
    strap = 1'b1;
    start_c(); send_byte(8'hB8, a); stop_c();
    chk("R1 B8 ignored strap1", {7'd0, a}, 8'h00);
    write_burst(8'h44, 8'h9E, 8'h00, 8'h00, 8'h00, 1);
    chk("R1 BA acked", {7'd0, ack_all}, 8'h01);
    read_burst(8'h44, 1); chk("R1 BB read", rbuf[0], 8'h9E);
    strap = 1'b0;

    // R6: clear auto-increment inside a burst
    write_burst(8'h10, 8'hAB, 8'h00, 8'h22, 8'h33, 4);
    read_burst(8'h12, 2);
    chk("R6 fixed b0", rbuf[0], 8'h33);
    chk("R6 fixed b1", rbuf[1], 8'h33);
    read_burst(8'h11, 1); chk("R6 ctrl cleared", rbuf[0], 8'h00);
    read_burst(8'h13, 1); chk("R6 next untouched", rbuf[0], 8'h00);
    read_burst(8'h10, 1); chk("R6 first byte", rbuf[0], 8'hAB);
    write_burst(8'h11, 8'h10, 8'h00, 8'h00, 8'h00, 1);
    read_burst(8'h10, 2);
    chk("R5 restored b0", rbuf[0], 8'hAB);
    chk("R5 restored b1", rbuf[1], 8'h10);

    // R9: NACK ends the read
    start_c();
    send_byte(adr(1'b0), a); send_byte(8'h30, a);
    start_c(); send_byte(adr(1'b1), a);
    recv_byte(1'b0, b); chk("R9 byte before nack", b, 8'h11);
    recv_byte(1'b0, b); chk("R9 released after nack", b, 8'hFF);
    stop_c();
    chk("R10 oe after stop", {7'd0, sda_oe}, 8'h00);

    // R10: START in the middle of a data byte
    start_c();
    send_byte(adr(1'b0), a); send_byte(8'h51, a);
    for (int i = 7; i >= 4; i--) begin
      sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0; wt(H/2);
    end
    start_c();
    send_byte(adr(1'b0), a); chk("R10 restart ack", {7'd0, a}, 8'h01);
    send_byte(8'h50, a); send_byte(8'h77, a);
    stop_c();
    read_burst(8'h50, 2);
    chk("R10 write after restart", rbuf[0], 8'h77);
    chk("R10 aborted byte dropped", rbuf[1], 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule